// File: doc/BRIEF.md
# Recency Stack with Bimodal Insertion

This block holds the replacement state of one cache set as an ordered list of way numbers, kept from most recently used (slot 0) to least recently used (the last slot). The way in the last slot is offered as the victim for the next fill. A hit moves the hit way to the front. What happens on a fill depends on an insertion mode chosen per access. The refilled line can go to the front, as in conventional LRU. It can stay in the last slot, which is LRU insertion. Or it can mostly stay in the last slot and only rarely go to the front, which is bimodal insertion.

The rare front insertion in bimodal mode comes from a free-running linear feedback shift register (LFSR). It fires about once in thirty-two fills. A line left at the LRU end is therefore evicted again on the next fill unless it is reused first. This stops a streaming workload from pushing useful lines out of the set. Tag storage, data arrays and the logic that picks the insertion mode belong to the surrounding cache. A combinational flag reports whether the stored list is still a permutation of the way numbers.

Top module: `recency_bip_set`

## Requirements
- R1: While `rst_n` is low and after its release, the list holds ways 0,1,...,7 from MRU to LRU, so `victim_way` reads 7 and `list_ok` reads 1.
- R2: `victim_way` always equals the way in the LRU slot of the current list, and it updates in the cycle after the access that changed the list.
- R3: An access with `acc_valid`=1 and `acc_hit`=1 moves `hit_way` to the MRU slot. The entries that were ahead of it move one slot toward LRU, and the entries behind it keep their slots.
- R4: A fill (`acc_valid`=1, `acc_hit`=0) with `ins_mode` 0 or 3 moves the current victim to the MRU slot, and every other entry moves one slot toward LRU.
- R5: A fill with `ins_mode`=2 (LRU insertion) leaves the order unchanged, so the same way is offered as the victim again.
- R6: A fill with `ins_mode`=1 (bimodal) behaves as R4 when the low 5 bits of the LFSR are all zero in the fill cycle, and as R5 otherwise.
- R7: The LFSR is 16 bits wide and shifts right in Galois form. When the bit shifted out is 1, the state is XORed with 0xB400. It resets to 0xACE1 and steps on every clock after reset, whether or not an access is presented.
- R8: A way that stayed in the LRU slot after a fill and is then hit moves to MRU like any other hit, and the next way in line becomes the victim.
- R9: A cycle with `acc_valid`=0 leaves the order unchanged.
- R10: `list_ok` is 1 exactly when the eight stored entries are a permutation of 0..7. It stays 1 under any legal access sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | An access to this set is presented this cycle |
| acc_hit | input | 1 | 1: the access hit `hit_way`; 0: the access is a fill into `victim_way` |
| hit_way | input | 3 | Way that hit (ignored on fills) |
| ins_mode | input | 2 | Fill insertion: 0 MRU, 1 bimodal, 2 LRU, 3 MRU |
| victim_way | output | 3 | Way at the LRU end, to be replaced by the next fill |
| list_ok | output | 1 | Stored order is a permutation of the way numbers |

## Verification
The checker module expects the cache around the block to present only legal accesses. A hit names a way that actually holds a line, the hit and fill cases are never presented together, and no input is unknown while `acc_valid` is high. With eight ways, every 3-bit `hit_way` value names a way present in the list, so the directed tests may pick any way for a hit. The tests drive `acc_hit` only as part of a full access word and keep inputs stable across each rising edge. The bench tracks the LFSR in its own model so that it knows, for each bimodal fill, whether front insertion is due.

// File: rtl/recency_pkg.sv
package recency_pkg;

   typedef enum logic [1:0] {
      INS_MRU     = 2'd0,
      INS_BIMODAL = 2'd1,
      INS_LRU     = 2'd2,
      INS_MRU_ALT = 2'd3
   } ins_mode_e;

   localparam int unsigned DEF_WAYS       = 8;
   localparam int unsigned DEF_LFSR_W     = 16;
   localparam logic [15:0] DEF_LFSR_TAPS  = 16'hB400;
   localparam logic [15:0] DEF_LFSR_SEED  = 16'hACE1;
   localparam int unsigned DEF_THROTTLE_W = 5;

   function automatic logic is_mru_mode(input logic [1:0] m);
      return (m == INS_MRU) || (m == INS_MRU_ALT);
   endfunction

endpackage

// File: rtl/rc_lfsr.sv
module rc_lfsr #(
   parameter int unsigned         W     = 16,
   parameter logic [W-1:0]        TAPS  = 16'hB400,
   parameter logic [W-1:0]        SEED  = 16'hACE1,
   parameter int unsigned         THR_W = 5
) (
   input  logic clk,
   input  logic rst_n,
   output logic rare
);

   if (W < 2) begin : g_bad_w
      $error("rc_lfsr: W must be at least 2");
   end
   if (THR_W > W) begin : g_bad_thr
      $error("rc_lfsr: THR_W must not exceed W");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("rc_lfsr: SEED must be nonzero");
   end

   logic [W-1:0] state;
   logic [W-1:0] state_nxt;

   always_comb begin
      state_nxt = {1'b0, state[W-1:1]};
      if (state[0]) state_nxt = state_nxt ^ TAPS;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= SEED;
      else        state <= state_nxt;
   end

   if (THR_W == 0) begin : g_always
      assign rare = 1'b1;
   end else begin : g_window
      assign rare = (state[THR_W-1:0] == '0);
   end

endmodule

// File: rtl/rc_order.sv
module rc_order #(
   parameter int unsigned WAYS  = 8,
   localparam int unsigned WAY_W = $clog2(WAYS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        move_en,
   input  logic                        use_hit,
   input  logic [WAY_W-1:0]            hit_way,
   output logic [WAYS-1:0][WAY_W-1:0]  order
);

   logic [WAYS-1:0]             match;
   logic [WAY_W-1:0]            hit_pos;
   logic [WAY_W-1:0]            pos;
   logic [WAYS-1:0][WAY_W-1:0]  order_nxt;

   for (genvar g = 0; g < WAYS; g++) begin : g_match
      assign match[g] = (order[g] == hit_way);
   end

   always_comb begin
      hit_pos = WAY_W'(WAYS - 1);
      for (int i = 0; i < WAYS; i++) begin
         if (match[i]) hit_pos = WAY_W'(i);
      end
   end

   assign pos = use_hit ? hit_pos : WAY_W'(WAYS - 1);

   for (genvar g = 0; g < WAYS; g++) begin : g_slot
      if (g == 0) begin : g_head
         assign order_nxt[g] = move_en ? order[pos] : order[g];
      end else begin : g_body
         assign order_nxt[g] = (move_en && (pos >= WAY_W'(g))) ? order[g-1] : order[g];
      end
   end

   for (genvar g = 0; g < WAYS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) order[g] <= WAY_W'(g);
         else        order[g] <= order_nxt[g];
      end
   end

endmodule

// File: rtl/rc_perm_chk.sv
module rc_perm_chk #(
   parameter int unsigned WAYS  = 8,
   localparam int unsigned WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0][WAY_W-1:0] order,
   output logic                       ok
);

   logic [WAYS-1:0] seen;

   always_comb begin
      seen = '0;
      for (int i = 0; i < WAYS; i++) begin
         seen[order[i]] = 1'b1;
      end
   end

   assign ok = &seen;

endmodule

// File: rtl/recency_bip_set.sv
module recency_bip_set #(
   parameter int unsigned  WAYS       = recency_pkg::DEF_WAYS,
   parameter int unsigned  LFSR_W     = recency_pkg::DEF_LFSR_W,
   parameter logic [15:0]  LFSR_TAPS  = recency_pkg::DEF_LFSR_TAPS,
   parameter logic [15:0]  LFSR_SEED  = recency_pkg::DEF_LFSR_SEED,
   parameter int unsigned  THROTTLE_W = recency_pkg::DEF_THROTTLE_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       acc_valid,
   input  logic                       acc_hit,
   input  logic [$clog2(WAYS)-1:0]    hit_way,
   input  logic [1:0]                 ins_mode,
   output logic [$clog2(WAYS)-1:0]    victim_way,
   output logic                       list_ok
);
   import recency_pkg::*;

   localparam int unsigned WAY_W = $clog2(WAYS);

   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("recency_bip_set: WAYS must be a power of two, at least 2");
   end
   if (LFSR_W != 16) begin : g_bad_lfsr
      $error("recency_bip_set: tap and seed parameters are 16 bits wide");
   end

   logic                       rare_evt;
   logic                       hit_acc;
   logic                       fill_acc;
   logic                       front_fill;
   logic                       move_en;
   logic [WAYS-1:0][WAY_W-1:0] order;

   rc_lfsr #(
      .W     (LFSR_W),
      .TAPS  (LFSR_TAPS),
      .SEED  (LFSR_SEED),
      .THR_W (THROTTLE_W)
   ) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .rare  (rare_evt)
   );

   assign hit_acc  = acc_valid &  acc_hit;
   assign fill_acc = acc_valid & ~acc_hit;

   always_comb begin
      unique case (ins_mode)
         INS_BIMODAL: front_fill = fill_acc & rare_evt;
         INS_LRU:     front_fill = 1'b0;
         default:     front_fill = fill_acc & is_mru_mode(ins_mode);
      endcase
   end

   assign move_en = hit_acc | front_fill;

   rc_order #(
      .WAYS (WAYS)
   ) u_order (
      .clk     (clk),
      .rst_n   (rst_n),
      .move_en (move_en),
      .use_hit (hit_acc),
      .hit_way (hit_way),
      .order   (order)
   );

   rc_perm_chk #(
      .WAYS (WAYS)
   ) u_perm (
      .order (order),
      .ok    (list_ok)
   );

   assign victim_way = order[WAYS-1];

endmodule

// File: rtl/rc_recency_chk.sv
module rc_recency_chk #(
   parameter int unsigned WAYS  = 8,
   localparam int unsigned WAY_W = $clog2(WAYS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             acc_valid,
   input logic             acc_hit,
   input logic [WAY_W-1:0] hit_way,
   input logic [1:0]       ins_mode,
   input logic             rare_evt,
   input logic [WAY_W-1:0] victim_way,
   input logic             list_ok
);

   logic fill_c;
   logic hit_c;
   assign fill_c = acc_valid & ~acc_hit;
   assign hit_c  = acc_valid &  acc_hit;

   AST_LIST_PERM: assert property (@(posedge clk) disable iff (!rst_n)
      list_ok); // R10

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> $stable(victim_way)); // R9

   AST_LRU_FILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      fill_c && ins_mode == 2'd2 |=> $stable(victim_way)); // R5

   AST_MRU_FILL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      fill_c && (ins_mode == 2'd0 || ins_mode == 2'd3) |=> victim_way != $past(victim_way)); // R4

   AST_BIMODAL_COLD: assert property (@(posedge clk) disable iff (!rst_n)
      fill_c && ins_mode == 2'd1 && !rare_evt |=> $stable(victim_way)); // R6

   AST_BIMODAL_HOT: assert property (@(posedge clk) disable iff (!rst_n)
      fill_c && ins_mode == 2'd1 && rare_evt |=> victim_way != $past(victim_way)); // R6

   AST_HIT_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
      hit_c && hit_way != victim_way |=> $stable(victim_way)); // R3

   AST_HIT_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
      hit_c && hit_way == victim_way |=> victim_way != $past(victim_way)); // R8

endmodule

bind recency_bip_set rc_recency_chk #(.WAYS(WAYS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .acc_valid  (acc_valid),
   .acc_hit    (acc_hit),
   .hit_way    (hit_way),
   .ins_mode   (ins_mode),
   .rare_evt   (rare_evt),
   .victim_way (victim_way),
   .list_ok    (list_ok)
);

// File: tb/tb_recency_bip_set.sv
module tb_recency_bip_set;

   localparam int NW = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_valid = 1'b0;
   logic       acc_hit = 1'b0;
   logic [2:0] hit_way = 3'd0;
   logic [1:0] ins_mode = 2'd0;
   logic [2:0] victim_way;
   logic       list_ok;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   int          mdl [NW];
   logic [15:0] ml;
   int          hot_cnt;
   int          cold_cnt;

   always #5 clk = ~clk;

   recency_bip_set dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_valid  (acc_valid),
      .acc_hit    (acc_hit),
      .hit_way    (hit_way),
      .ins_mode   (ins_mode),
      .victim_way (victim_way),
      .list_ok    (list_ok)
   );

   // independent LFSR model (R7)
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) ml <= 16'hACE1;
      else        ml <= {1'b0, ml[15:1]} ^ (ml[0] ? 16'hB400 : 16'h0000);
   end

   task automatic chk(input bit good, input string req, input int act, input int exp);
      tests++;
      if (!good) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < NW; i++) mdl[i] = i;
   endtask

   function automatic void model_step(input bit v, input bit h, input int w, input int mode);
      int pos;
      int t;
      if (!v) return;
      if (h) begin
         pos = 0;
         for (int i = 0; i < NW; i++) if (mdl[i] == w) pos = i;
      end else begin
         if (mode == 2) return;
         if (mode == 1) begin
            if (ml[4:0] != 5'd0) begin cold_cnt++; return; end
            hot_cnt++;
         end
         pos = NW - 1;
      end
      t = mdl[pos];
      for (int i = pos; i > 0; i--) mdl[i] = mdl[i-1];
      mdl[0] = t;
   endfunction

   task automatic check_state(input string req);
      chk(victim_way == 3'(mdl[NW-1]), req, int'(victim_way), mdl[NW-1]);
      chk(list_ok == 1'b1, "R10", int'(list_ok), 1);
   endtask

   task automatic acc(input bit v, input bit h, input int w, input int mode, input string req);
      @(negedge clk);
      check_state(req);
      acc_valid = v;
      acc_hit   = h;
      hit_way   = 3'(w);
      ins_mode  = 2'(mode);
      model_step(v, h, w, mode);
   endtask

   task automatic settle(input string req);
      acc(1'b0, 1'b0, 0, 0, req);
      @(negedge clk);
      check_state(req);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      acc_valid = 1'b0;
      model_reset();
      repeat (3) @(negedge clk);
      chk(victim_way == 3'd7, "R1", int'(victim_way), 7);
      chk(list_ok == 1'b1, "R1", int'(list_ok), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(victim_way == 3'd7, "R1", int'(victim_way), 7);
   endtask

   task automatic t_mru_fills();
      for (int k = 0; k < 10; k++) acc(1'b1, 1'b0, 0, (k % 3 == 2) ? 3 : 0, "R4");
      settle("R2");
   endtask

   task automatic t_lru_fills();
      for (int k = 0; k < 5; k++) acc(1'b1, 1'b0, 0, 2, "R5");
      settle("R5");
   endtask

   task automatic t_idle();
      for (int k = 0; k < 6; k++) acc(1'b0, k[0], k, 0, "R9");
      settle("R9");
   endtask

   task automatic t_hits();
      acc(1'b1, 1'b1, 3, 0, "R3");
      acc(1'b1, 1'b1, 6, 2, "R3");
      acc(1'b1, 1'b1, 3, 1, "R3");
      acc(1'b1, 1'b1, 0, 0, "R3");
      acc(1'b1, 1'b1, mdl[NW-1], 0, "R3");
      // read the full order back through eight conventional fills
      for (int k = 0; k < NW; k++) acc(1'b1, 1'b0, 0, 0, "R3");
      settle("R3");
   endtask

   task automatic t_lru_reuse();
      int v0;
      acc(1'b1, 1'b0, 0, 2, "R8");
      v0 = mdl[NW-1];
      acc(1'b1, 1'b1, v0, 0, "R8");
      settle("R8");
      chk(mdl[0] == v0 && victim_way != 3'(v0), "R8", int'(victim_way), mdl[NW-1]);
   endtask

   task automatic t_bimodal();
      hot_cnt = 0;
      cold_cnt = 0;
      for (int k = 0; k < 600; k++) begin
         acc(1'b1, 1'b0, 0, 1, "R6");
         if (k % 7 == 3) acc(1'b0, 1'b0, 0, 1, "R7");
         if (k % 11 == 5) acc(1'b1, 1'b1, k % NW, 1, "R3");
      end
      settle("R6");
      chk(hot_cnt >= 2, "R6", hot_cnt, 2);
      chk(cold_cnt > 8 * hot_cnt, "R6", cold_cnt, 8 * hot_cnt);
   endtask

   task automatic t_reset_again();
      @(negedge clk);
      rst_n = 1'b0;
      model_reset();
      @(negedge clk);
      chk(victim_way == 3'd7, "R1", int'(victim_way), 7);
      rst_n = 1'b1;
      for (int k = 0; k < 40; k++) acc(1'b1, 1'b0, 0, 1, "R7");
      settle("R7");
   endtask

   initial begin
      t_reset();
      t_mru_fills();
      t_lru_fills();
      t_idle();
      t_hits();
      t_lru_reuse();
      t_bimodal();
      t_reset_again();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         tests++;
         fails++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule